// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block turns the bus clock into an SPI serial clock. A single divider field feeds one of two division laws, and a law-select bit picks which one applies. Under the exponential law only the low bits of the field count, and the serial clock period is a power of two in bus clocks. Under the linear law the whole field counts, and the period is an even number of bus clocks. A half-period counter reloads on each serial clock toggle. Polarity sets the level the clock rests at. Phase decides which toggle is the sampling edge and which is the shifting edge.

The serial clock runs while `enable` is high. While `enable` is low, the clock rests at its idle level and the settings (law, divider, polarity, phase) follow the inputs. While `enable` is high, the settings stay frozen at the values captured before the block was enabled. A shifter outside this block consumes the strobes. This block has no knowledge of frames or data.

Top module: `spi_dual_clkdiv`

## Requirements
- R1: With `law_sel` = 0, the serial clock period is 2^(N+1) bus clocks, where N is the low 4 bits of `div_val`. Bits 7:4 have no effect.
- R2: With `law_sel` = 1, the serial clock period is 2*(N+1) bus clocks, where N is the full 8-bit `div_val` (0 to 255).
- R3: After `enable` rises, the first serial clock toggle away from idle occurs H bus clocks after the first clock edge that samples `enable` high. H is half the period from R1 or R2.
- R4: While `enable` has been low since the previous clock edge, `sclk` equals the `cpol` input value at that edge, and all four strobes are 0.
- R5: `lead_stb` is a one-cycle pulse in the cycle `sclk` leaves the idle level. `trail_stb` is a one-cycle pulse in the cycle `sclk` returns to idle. The two are never high together, and `trail_stb` comes H cycles after `lead_stb`.
- R6: With `cpha` = 0, `sample_stb` equals `lead_stb` and `shift_stb` equals `trail_stb`. With `cpha` = 1, the pairs are swapped.
- R7: Changes to `law_sel`, `div_val`, `cpol` and `cpha` while enabled do not alter the running period, the clock level or the strobe mapping.
- R8: `sclk` changes level while enabled only together with a strobe. After `enable` falls, `sclk` is at the idle level of the current `cpol` input one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the serial clock; low freezes it at idle |
| law_sel | input | 1 | 0 = exponential law, 1 = linear law |
| div_val | input | DIV_W (8) | Divider field shared by both laws |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | Pulse: sclk left idle this cycle |
| trail_stb | output | 1 | Pulse: sclk returned to idle this cycle |
| sample_stb | output | 1 | Pulse: receive sample point for the selected phase |
| shift_stb | output | 1 | Pulse: transmit shift point for the selected phase |

## Verification
A wrong counter limit or a wrong choice of law shows up as a serial clock period that is off by a measurable number of bus clocks, within one period of enabling. A toggle state that falls out of step with polarity shows as `sclk` at the wrong level on the first strobe, or as a trail strobe at the wrong offset. A settings register that fails to freeze shows as a period or idle level that changes when the inputs are disturbed in mid-run, within the next half period. A register that fails to follow the inputs while disabled shows as the wrong idle level one clock after disable.

// File: rtl/spi_dual_clkdiv_pkg.sv
package spi_dual_clkdiv_pkg;
   // law selector values
   localparam logic LAW_EXP = 1'b0;
   localparam logic LAW_LIN = 1'b1;

   // settings captured while the divider is idle
   typedef struct packed {
      logic law;
      logic cpol;
      logic cpha;
   } sclk_mode_t;
endpackage

// File: rtl/sdc_cfg_hold.sv
module sdc_cfg_hold
   import spi_dual_clkdiv_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             law_in,
   input  logic [DIV_W-1:0] div_in,
   input  logic             cpol_in,
   input  logic             cpha_in,
   output sclk_mode_t       mode_q,
   output logic [DIV_W-1:0] div_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         div_q  <= '0;
      end else if (!enable) begin
         mode_q.law  <= law_in;
         mode_q.cpol <= cpol_in;
         mode_q.cpha <= cpha_in;
         div_q       <= div_in;
      end
   end
endmodule

// File: rtl/sdc_half_timer.sv
module sdc_half_timer
   import spi_dual_clkdiv_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int EXP_W = 4,
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             law,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [EXP_W-1:0] exp_n;
   logic [CNT_W-1:0] exp_lim;
   logic [CNT_W-1:0] lin_lim;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt_q;

   assign exp_n = div[EXP_W-1:0];

   // exponential law: half period 2^N, limit is a mask of N ones
   for (genvar i = 0; i < CNT_W; i++) begin : g_exp_mask
      assign exp_lim[i] = ({{(32-EXP_W){1'b0}}, exp_n} > 32'(i));
   end

   // linear law: half period N+1, limit is N itself
   if (CNT_W > DIV_W) begin : g_lin_wide
      assign lin_lim = {{(CNT_W-DIV_W){1'b0}}, div};
   end else begin : g_lin_same
      assign lin_lim = div;
   end

   assign lim  = (law == LAW_LIN) ? lin_lim : exp_lim;
   assign tick = enable && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!enable)  cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sdc_edge_gen.sv
module sdc_edge_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic tick,
   input  logic cpol,
   input  logic cpha,
   output logic sclk,
   output logic lead_stb,
   output logic trail_stb,
   output logic sample_stb,
   output logic shift_stb
);
   logic active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (!enable) begin
         active_q  <= 1'b0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else begin
         if (tick) active_q <= !active_q;
         lead_stb  <= tick && !active_q;
         trail_stb <= tick &&  active_q;
      end
   end

   assign sclk       = active_q ^ cpol;
   assign sample_stb = cpha ? trail_stb : lead_stb;
   assign shift_stb  = cpha ? lead_stb  : trail_stb;
endmodule

// File: rtl/spi_dual_clkdiv.sv
module spi_dual_clkdiv
   import spi_dual_clkdiv_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             law_sel,
   input  logic [DIV_W-1:0] div_val,
   input  logic             cpol,
   input  logic             cpha,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb,
   output logic             sample_stb,
   output logic             shift_stb
);
   localparam int EXP_SPAN = (1 << EXP_W) - 1;
   localparam int CNT_W    = (EXP_SPAN > DIV_W) ? EXP_SPAN : DIV_W;

   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("EXP_W must lie in 1..5");
   end
   if (EXP_W > DIV_W) begin : g_bad_div
      $error("EXP_W must not exceed DIV_W");
   end

   sclk_mode_t       mode_q;
   logic [DIV_W-1:0] div_q;
   logic             tick;

   sdc_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .law_in(law_sel), .div_in(div_val), .cpol_in(cpol), .cpha_in(cpha),
      .mode_q(mode_q), .div_q(div_q)
   );

   sdc_half_timer #(.DIV_W(DIV_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .law(mode_q.law), .div(div_q), .tick(tick)
   );

   sdc_edge_gen u_edge (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
      .cpol(mode_q.cpol), .cpha(mode_q.cpha),
      .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb),
      .sample_stb(sample_stb), .shift_stb(shift_stb)
   );
endmodule

// File: rtl/spi_dual_clkdiv_chk.sv
module spi_dual_clkdiv_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic cpol,
   input logic sclk,
   input logic lead_stb,
   input logic trail_stb,
   input logic sample_stb,
   input logic shift_stb
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R4
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(enable) |-> (sclk == $past(cpol)) && !lead_stb && !trail_stb);

   // R5
   edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));

   // R5
   lead_moves_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      lead_stb |-> (sclk != $past(sclk)) || !$past(enable, 2));

   // R6
   phase_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sample_stb, shift_stb}) && ((sample_stb || shift_stb) == (lead_stb || trail_stb)));

   // R8
   sclk_moves_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      ($past(enable) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb));
endmodule

bind spi_dual_clkdiv spi_dual_clkdiv_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .sclk(sclk),
   .lead_stb(lead_stb), .trail_stb(trail_stb),
   .sample_stb(sample_stb), .shift_stb(shift_stb)
);

// File: tb/spi_dual_clkdiv_test.sv
`timescale 1ns/1ps
module spi_dual_clkdiv_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       law_sel = 1'b0;
   logic [7:0] div_val = 8'd0;
   logic       cpol = 1'b0;
   logic       cpha = 1'b0;
   logic       sclk, lead_stb, trail_stb, sample_stb, shift_stb;
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   spi_dual_clkdiv uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .law_sel(law_sel),
      .div_val(div_val), .cpol(cpol), .cpha(cpha), .sclk(sclk),
      .lead_stb(lead_stb), .trail_stb(trail_stb),
      .sample_stb(sample_stb), .shift_stb(shift_stb)
   );

   function automatic int half_of(input bit law, input logic [7:0] d);
      return law ? (int'(d) + 1) : (1 << d[3:0]);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_case(input bit law, input logic [7:0] d, input bit pol,
                           input bit pha, input bit disturb);
      int    h = half_of(law, d);
      string rq = law ? "R2" : "R1";
      int    c;
      int    tpos;
      @(negedge clk);
      enable = 0; law_sel = law; div_val = d; cpol = pol; cpha = pha;
      repeat (3) @(negedge clk);
      // R4: idle level and quiet strobes while disabled
      chk(sclk == pol && !lead_stb && !trail_stb, "R4", "idle sclk", sclk, pol);
      enable = 1;
      c = 0;
      do begin @(negedge clk); c++; end while (sclk == pol && c < 70000);
      // R3: first toggle after H clocks
      chk(c == h, "R3", "first toggle delay", c, h);
      // R5: leading strobe with the toggle
      chk(lead_stb && !trail_stb, "R5", "lead strobe at first toggle", lead_stb, 1);
      // R6: phase mapping on the leading edge
      chk(sample_stb == !pha && shift_stb == pha, "R6", "lead mapping", sample_stb, !pha);
      if (disturb) begin
         law_sel = !law; div_val = ~d; cpol = !pol; cpha = !pha;
      end
      for (int k = 0; k < 2; k++) begin
         c = 0; tpos = -1;
         do begin
            @(negedge clk); c++;
            if (trail_stb) begin
               tpos = c;
               chk(sclk == pol, "R5", "sclk at trail", sclk, pol);
               chk(sample_stb == pha && shift_stb == !pha, "R6", "trail mapping", sample_stb, pha);
            end
         end while (!lead_stb && c < 140000);
         chk(c == 2 * h, disturb ? "R7" : rq, "period", c, 2 * h);
         chk(tpos == h, "R5", "trail offset", tpos, h);
         chk(sclk == !pol, disturb ? "R7" : "R5", "sclk at lead", sclk, !pol);
      end
      enable = 0;
      @(negedge clk);
      // R8: idle one clock after disable, following current polarity input
      chk(sclk == cpol && !lead_stb && !trail_stb, "R8", "sclk after disable", sclk, cpol);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0017));
      repeat (3) @(negedge clk);
      // reset state
      chk(sclk == 1'b0 && !lead_stb && !trail_stb, "R4", "reset state", sclk, 0);
      rst_n = 1;
      // directed corners
      run_case(0, 8'h00, 0, 0, 0);   // fastest exponential
      run_case(1, 8'h00, 1, 1, 0);   // fastest linear
      run_case(0, 8'hF3, 1, 0, 0);   // R1 upper bits ignored
      run_case(0, 8'h0C, 0, 1, 0);   // larger exponent
      run_case(1, 8'hFF, 0, 0, 0);   // largest linear
      run_case(1, 8'd5, 0, 1, 1);    // R7 disturb while running
      run_case(0, 8'h02, 1, 1, 1);   // R7 disturb exponential
      // random mix
      for (int i = 0; i < 16; i++) begin
         bit         l = 1'($urandom);
         logic [7:0] d = l ? 8'($urandom) : {4'($urandom), 1'b0, 3'($urandom)};
         run_case(l, d, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0));
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule